// File: doc/BRIEF.md
# Four-Channel DMA Controller

This block moves data between peripherals and memory on behalf of a host processor. While it is not bus master, the host reaches a small register window a byte at a time. Each of the four channels has a 16-bit start address and a 16-bit transfer count. One mode byte is shared by all channels and holds the channel enables, a stop-at-terminal-count option and the transfer direction. One status byte is also shared and records which channels have reached terminal count.

When an enabled channel's peripheral raises its request, the block asks the host for the bus. Once the host grants the bus, the block runs back-to-back single transfers. Each transfer drives the low address byte on dedicated pins. The high address byte goes out on the data pins together with a strobe, so that an external latch can capture it; this happens only when the latch contents would otherwise be stale. A paired memory strobe and I/O strobe carry the data, and an acknowledge goes to the serviced channel. Channel 0 always wins when several channels request at once.

Top module: `dma4_ctrl`

## Requirements
- R1: An active-low asynchronous reset clears every address, count, mode and status bit and the byte pointer. After reset hrq, ctl_oe, d_oe, adstb and dack are 0, and no request can raise hrq until the mode byte is written.
- R2: Register window, decoded from a_i while the block is idle and cs is high. When a_i[3]=0, a_i[2:1] selects the channel and a_i[0] selects the register (0 = address, 1 = count). When a_i[3]=1, a write loads the mode byte and a read returns the status byte. Channel registers are accessed low byte first, then high byte, through a shared byte pointer that toggles on every channel-register access.
- R3: A mode write returns the byte pointer to the low byte, even after an odd number of channel accesses.
- R4: Mode bits [3:0] enable channels 0 to 3. A request on a disabled channel is ignored and leaves hrq at 0. A request on an enabled channel raises hrq, and transfers start only after hlda.
- R5: When several enabled channels request at once, the lowest-numbered channel is served first. At most one dack bit is high at a time.
- R6: Mode bit 5 selects the direction. When it is 1, each transfer pulses io_rd_o and mem_wr. When it is 0, each transfer pulses mem_rd and io_wr_o. The strobes are active only in the cycle dack is high.
- R7: After each transfer the channel's address increments by one and its count decrements by one, both wrapping modulo 2^16. The new values are readable through the register window.
- R8: tc is high during a transfer whose count was 0 beforehand. Such a transfer sets status bit n for channel n, and a status read clears all status bits.
- R9: If mode bit 4 (stop at terminal count) is set, the transfer that raises tc clears that channel's enable bit, and no further transfer occurs on that channel.
- R10: During a transfer, a_o carries address bits [7:0]. The high byte appears on d_o with adstb and d_oe high. This happens in the first address cycle after a bus grant and in any later address cycle where bits [15:8] differ from the last latched value; otherwise adstb stays low.
- R11: ctl_oe is 1 only while the block owns the bus. Outside bus ownership, all memory and I/O strobes, adstb and dack stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Register window select |
| io_rd_i | input | 1 | Host read strobe (slave side) |
| io_wr_i | input | 1 | Host write strobe (slave side) |
| a_i | input | 4 | Register window address |
| d_i | input | 8 | Host write data |
| d_o | output | 8 | Read data, or high address byte while adstb |
| d_oe | output | 1 | Data pins driven |
| dreq | input | 4 | Peripheral service requests |
| dack | output | 4 | Peripheral acknowledges |
| hrq | output | 1 | Bus request to host |
| hlda | input | 1 | Bus grant from host |
| a_o | output | 8 | Low address byte |
| adstb | output | 1 | High-address latch strobe |
| aen | output | 1 | Address cycle active (bus owned) |
| ctl_oe | output | 1 | Master strobes driven |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe (master side) |
| io_wr_o | output | 1 | I/O write strobe (master side) |
| tc | output | 1 | Terminal-count transfer |

## Verification
A wrong address or count register appears on the pins at that channel's next transfer, as a mismatch on a_o or on the latched high byte. It also shows in the next register readback. A stale high-byte record shows up differently: adstb is missing or extra in the very next address cycle, so the assembled 16-bit address is wrong in the same transfer. A byte pointer left on the wrong phase swaps the high and low bytes on the next host access. A channel whose enable survives terminal count with stop set produces a further dack within a few cycles, while its request is still held.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;

  typedef logic [REG_W-1:0]  reg_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_ADDR,
    ST_XFER,
    ST_GAP
  } eng_st_e;

  function automatic reg_t addr_step(reg_t a);
    return a + reg_t'(1);
  endfunction

  function automatic reg_t count_step(reg_t c);
    return c - reg_t'(1);
  endfunction

  function automatic logic count_is_tc(reg_t c);
    return c == '0;
  endfunction

  function automatic byte_t upper_of(reg_t v);
    return v[REG_W-1:REG_W-BYTE_W];
  endfunction

  function automatic byte_t lower_of(reg_t v);
    return v[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/dma4_regs.sv
module dma4_regs
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [CHW-1:0]             wr_ch,
  input  logic                       wr_cnt,
  input  logic                       wr_hi,
  input  byte_t                      wr_data,
  input  logic                       upd,
  input  logic [CHW-1:0]             upd_ch,
  output logic [NCH-1:0][REG_W-1:0]  addr_q,
  output logic [NCH-1:0][REG_W-1:0]  cnt_q
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    reg_t a_r, n_r;
    logic sel_w, sel_u;
    assign sel_w = wr_en && (wr_ch == CHW'(c));
    assign sel_u = upd && (upd_ch == CHW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_r <= '0;
        n_r <= '0;
      end else if (sel_w) begin
        if (wr_cnt) begin
          if (wr_hi) n_r[REG_W-1:BYTE_W] <= wr_data;
          else       n_r[BYTE_W-1:0]     <= wr_data;
        end else begin
          if (wr_hi) a_r[REG_W-1:BYTE_W] <= wr_data;
          else       a_r[BYTE_W-1:0]     <= wr_data;
        end
      end else if (sel_u) begin
        a_r <= addr_step(a_r);
        n_r <= count_step(n_r);
      end
    end

    assign addr_q[c] = a_r;
    assign cnt_q[c]  = n_r;
  end
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCH-1:0]             req,
  input  logic                       hlda,
  input  logic [NCH-1:0][REG_W-1:0]  addr_q,
  input  logic [NCH-1:0][REG_W-1:0]  cnt_q,
  input  logic                       dir_wr,
  output logic                       idle,
  output logic                       hrq,
  output logic                       aen,
  output logic                       adstb,
  output byte_t                      a_lo,
  output byte_t                      a_hi,
  output logic [NCH-1:0]             dack,
  output logic                       mem_rd,
  output logic                       mem_wr,
  output logic                       io_rd_o,
  output logic                       io_wr_o,
  output logic                       tc,
  output logic                       done,
  output logic [CHW-1:0]             cur_ch
);
  eng_st_e st_q, st_d;
  logic    hi_valid;
  byte_t   last_hi;
  reg_t    cur_addr, cur_cnt;
  logic    any_req, in_xfer, take;

  function automatic logic [CHW-1:0] pick(logic [NCH-1:0] r);
    logic [CHW-1:0] p = '0;
    for (int i = NCH - 1; i >= 0; i--) if (r[i]) p = CHW'(i);
    return p;
  endfunction

  assign any_req  = |req;
  assign cur_addr = addr_q[cur_ch];
  assign cur_cnt  = cnt_q[cur_ch];
  assign in_xfer  = (st_q == ST_XFER);
  assign take     = ((st_q == ST_HOLD) || (st_q == ST_GAP)) && hlda && any_req;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (any_req) st_d = ST_HOLD;
      ST_HOLD: if (!any_req) st_d = ST_IDLE; else if (hlda) st_d = ST_ADDR;
      ST_ADDR: st_d = ST_XFER;
      ST_XFER: st_d = ST_GAP;
      ST_GAP:  st_d = take ? ST_ADDR : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cur_ch   <= '0;
      hi_valid <= 1'b0;
      last_hi  <= '0;
    end else begin
      st_q <= st_d;
      if (take) cur_ch <= pick(req);
      if (st_q == ST_IDLE || st_q == ST_HOLD) hi_valid <= 1'b0;
      else if (in_xfer) begin
        hi_valid <= 1'b1;
        last_hi  <= upper_of(cur_addr);
      end
    end
  end

  assign idle    = (st_q == ST_IDLE);
  assign hrq     = !idle;
  assign aen     = (st_q == ST_ADDR) || in_xfer || (st_q == ST_GAP);
  assign adstb   = (st_q == ST_ADDR) && (!hi_valid || (upper_of(cur_addr) != last_hi));
  assign a_lo    = lower_of(cur_addr);
  assign a_hi    = upper_of(cur_addr);
  assign dack    = in_xfer ? ({{(NCH-1){1'b0}}, 1'b1} << cur_ch) : '0;
  assign mem_wr  = in_xfer && dir_wr;
  assign io_rd_o = in_xfer && dir_wr;
  assign mem_rd  = in_xfer && !dir_wr;
  assign io_wr_o = in_xfer && !dir_wr;
  assign tc      = in_xfer && count_is_tc(cur_cnt);
  assign done    = in_xfer;
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs,
  input  logic           io_rd_i,
  input  logic           io_wr_i,
  input  logic [3:0]     a_i,
  input  logic [7:0]     d_i,
  output logic [7:0]     d_o,
  output logic           d_oe,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  output logic           hrq,
  input  logic           hlda,
  output logic [7:0]     a_o,
  output logic           adstb,
  output logic           aen,
  output logic           ctl_oe,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           io_rd_o,
  output logic           io_wr_o,
  output logic           tc
);
  localparam int CHW    = $clog2(NCH);
  localparam int TCS_B  = NCH;
  localparam int DIR_B  = NCH + 1;
  localparam int MODE_W = NCH + 2;

  logic [MODE_W-1:0]         mode_q;
  logic [NCH-1:0]            flags;
  logic                      bptr;
  logic [NCH-1:0][REG_W-1:0] addr_q, cnt_q;
  logic                      idle, xfer_done, tc_hit, stat_rd;
  logic                      slv_wr, slv_rd, sel_mode, chan_wr;
  logic [CHW-1:0]            cur_ch, sel_ch;
  logic [NCH-1:0]            mode_en;
  logic                      tc_stop;
  byte_t                     a_hi, rd_byte;
  reg_t                      sel_reg;

  assign slv_wr   = cs && io_wr_i && idle;
  assign slv_rd   = cs && io_rd_i && idle;
  assign sel_mode = a_i[3];
  assign sel_ch   = a_i[CHW:1];
  assign chan_wr  = slv_wr && !sel_mode;
  assign stat_rd  = slv_rd && sel_mode;
  assign mode_en  = mode_q[NCH-1:0];
  assign tc_stop  = mode_q[TCS_B];
  assign tc_hit   = xfer_done && tc;

  dma4_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(chan_wr), .wr_ch(sel_ch), .wr_cnt(a_i[0]), .wr_hi(bptr), .wr_data(d_i),
    .upd(xfer_done), .upd_ch(cur_ch),
    .addr_q(addr_q), .cnt_q(cnt_q)
  );

  dma4_engine #(.NCH(NCH)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .req(dreq & mode_en), .hlda(hlda),
    .addr_q(addr_q), .cnt_q(cnt_q), .dir_wr(mode_q[DIR_B]),
    .idle(idle), .hrq(hrq), .aen(aen), .adstb(adstb),
    .a_lo(a_o), .a_hi(a_hi), .dack(dack),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd_o(io_rd_o), .io_wr_o(io_wr_o),
    .tc(tc), .done(xfer_done), .cur_ch(cur_ch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      flags  <= '0;
      bptr   <= 1'b0;
    end else begin
      if (slv_wr && sel_mode) begin
        mode_q <= d_i[MODE_W-1:0];
        bptr   <= 1'b0;
      end else if ((slv_wr || slv_rd) && !sel_mode) begin
        bptr <= !bptr;
      end
      if (tc_hit) begin
        flags[cur_ch] <= 1'b1;
        if (tc_stop) mode_q[cur_ch] <= 1'b0;
      end else if (stat_rd) begin
        flags <= '0;
      end
    end
  end

  assign sel_reg = a_i[0] ? cnt_q[sel_ch] : addr_q[sel_ch];
  assign rd_byte = sel_mode ? byte_t'(flags)
                 : (bptr ? upper_of(sel_reg) : lower_of(sel_reg));
  assign d_o     = adstb ? a_hi : rd_byte;
  assign d_oe    = adstb || slv_rd;
  assign ctl_oe  = aen;
endmodule

// File: rtl/dma4_ctrl_chk.sv
module dma4_ctrl_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hrq,
  input logic           aen,
  input logic           adstb,
  input logic           ctl_oe,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           io_rd_o,
  input logic           io_wr_o,
  input logic [NCH-1:0] dack,
  input logic           tc_hit,
  input logic           tc_stop,
  input logic [NCH-1:0] mode_en,
  input logic           stat_rd,
  input logic [NCH-1:0] flags
);
  a_r5_one_dack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  a_r4_dack_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dack != '0) |-> hrq);

  a_r6_strobe_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (dack != '0) |-> ((mem_wr == io_rd_o) && (mem_rd == io_wr_o) && (mem_wr != mem_rd)));

  a_r10_first_stb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aen) |-> adstb);

  a_r9_stop_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_hit && tc_stop) |=> ((mode_en & $past(dack)) == '0));

  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    tc_hit |=> ((flags & $past(dack)) != '0));

  a_r8_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (flags == '0));

  a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !hrq |-> !(ctl_oe || mem_rd || mem_wr || io_rd_o || io_wr_o || adstb || (dack != '0)));
endmodule

bind dma4_ctrl dma4_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hrq(hrq), .aen(aen), .adstb(adstb), .ctl_oe(ctl_oe),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd_o(io_rd_o), .io_wr_o(io_wr_o),
  .dack(dack), .tc_hit(tc_hit), .tc_stop(tc_stop), .mode_en(mode_en),
  .stat_rd(stat_rd), .flags(flags)
);

// File: tb/sim_dma4_ctrl.sv
module sim_dma4_ctrl;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, cs = 0, io_rd_i = 0, io_wr_i = 0, hlda = 0;
  logic [3:0] a_i = '0;
  logic [7:0] d_i = '0, d_o, a_o;
  logic d_oe, hrq, adstb, aen, ctl_oe, mem_rd, mem_wr, io_rd_o, io_wr_o, tc;
  logic [NCH-1:0] dreq = '0, dack;

  dma4_ctrl #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .io_rd_i(io_rd_i), .io_wr_i(io_wr_i),
    .a_i(a_i), .d_i(d_i), .d_o(d_o), .d_oe(d_oe), .dreq(dreq), .dack(dack),
    .hrq(hrq), .hlda(hlda), .a_o(a_o), .adstb(adstb), .aen(aen), .ctl_oe(ctl_oe),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd_o(io_rd_o), .io_wr_o(io_wr_o), .tc(tc)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [15:0] maddr[NCH], mcnt[NCH];
  logic [NCH-1:0] men = '0, mflag = '0;
  bit mtcs = 0, mdir = 0, first_x = 1, stb_seen = 0;
  logic [7:0] hi_latch = '0, m_last_hi = '0;
  int rem[NCH], nx[NCH], log_ch[64], log_n = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_pick(logic [NCH-1:0] r);
    for (int i = 0; i < NCH; i++) if (r[i]) return i;
    return -1;
  endfunction

  function automatic logic [15:0] inc16(logic [15:0] v);
    return 16'((int'(v) + 1) % 65536);
  endfunction

  function automatic logic [15:0] dec16(logic [15:0] v);
    return (v == 16'h0) ? 16'hFFFF : 16'(int'(v) - 1);
  endfunction

  task automatic model_clear();
    for (int c = 0; c < NCH; c++) begin
      maddr[c] = '0; mcnt[c] = '0; rem[c] = 0; nx[c] = 0;
    end
    men = '0; mflag = '0; mtcs = 0; mdir = 0;
  endtask

  task automatic cpu_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1; io_wr_i = 1; a_i = a; d_i = d;
    @(negedge clk);
    cs = 0; io_wr_i = 0;
  endtask

  task automatic cpu_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1; io_rd_i = 1; a_i = a;
    #1 d = d_o;
    chk(d_oe == 1'b1, "R2", "d_oe on read", d_oe, 1);
    @(negedge clk);
    cs = 0; io_rd_i = 0;
  endtask

  task automatic wr16(input int ch, input bit is_cnt, input logic [15:0] v);
    logic [3:0] a = {1'b0, 2'(ch), is_cnt};
    cpu_wr(a, v[7:0]);
    cpu_wr(a, v[15:8]);
    if (is_cnt) mcnt[ch] = v; else maddr[ch] = v;
  endtask

  task automatic rd16(input int ch, input bit is_cnt, output logic [15:0] v);
    logic [3:0] a = {1'b0, 2'(ch), is_cnt};
    logic [7:0] lo, hi;
    cpu_rd(a, lo);
    cpu_rd(a, hi);
    v = {hi, lo};
  endtask

  task automatic wr_mode(input logic [7:0] m);
    cpu_wr(4'h8, m);
    men = m[3:0]; mtcs = m[4]; mdir = m[5];
  endtask

  task automatic check_regs(input string req);
    logic [15:0] v;
    for (int c = 0; c < NCH; c++) begin
      rd16(c, 0, v); chk(v == maddr[c], req, $sformatf("addr ch%0d", c), v, maddr[c]);
      rd16(c, 1, v); chk(v == mcnt[c],  req, $sformatf("count ch%0d", c), v, mcnt[c]);
    end
  endtask

  task automatic check_status(input string req);
    logic [7:0] s;
    cpu_rd(4'h8, s);
    chk(s == {4'h0, mflag}, req, "status", s, {4'h0, mflag});
    mflag = '0;
    cpu_rd(4'h8, s);
    chk(s == 8'h00, "R8", "status after read", s, 0);
  endtask

  // host grant model
  initial forever begin
    @(negedge clk);
    hlda = hrq;
  end

  // bus monitor and peripheral model
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (!hrq)
        chk(!(ctl_oe || mem_rd || mem_wr || io_rd_o || io_wr_o || adstb || dack != 0),
            "R11", "quiet outside ownership",
            {ctl_oe, mem_rd, mem_wr, io_rd_o, io_wr_o, adstb}, 0);
      if (!aen) first_x = 1;
      if (adstb) begin
        stb_seen = 1; hi_latch = d_o;
        chk(d_oe, "R10", "d_oe with adstb", d_oe, 1);
      end
      if (dack != '0) begin
        int ch, ep;
        bit exp_stb, exp_tc;
        ch = exp_pick(dack);
        ep = exp_pick(dreq & men);
        chk($countones(dack) == 1, "R5", "one dack", dack, 1);
        chk(ch == ep, "R5", "priority channel", ch, ep);
        exp_stb = first_x || (maddr[ch][15:8] != m_last_hi);
        chk(stb_seen == exp_stb, "R10", "adstb need", stb_seen, exp_stb);
        chk({hi_latch, a_o} == maddr[ch], "R10", "bus address", {hi_latch, a_o}, maddr[ch]);
        exp_tc = (mcnt[ch] == 16'h0);
        chk(tc == exp_tc, "R8", "tc", tc, exp_tc);
        chk(mdir ? (io_rd_o && mem_wr && !mem_rd && !io_wr_o)
                 : (mem_rd && io_wr_o && !mem_wr && !io_rd_o), "R6", "strobes",
            {mem_rd, mem_wr, io_rd_o, io_wr_o}, mdir ? 4'b0110 : 4'b1001);
        m_last_hi = maddr[ch][15:8];
        maddr[ch] = inc16(maddr[ch]);
        mcnt[ch]  = dec16(mcnt[ch]);
        if (exp_tc) begin
          mflag[ch] = 1'b1;
          if (mtcs) men[ch] = 1'b0;
        end
        if (log_n < 64) log_ch[log_n] = ch;
        log_n++;
        nx[ch]++;
        rem[ch]--;
        if (rem[ch] <= 0) dreq[ch] = 1'b0;
        first_x = 0; stb_seen = 0;
      end
    end
  end

  task automatic start_reqs();
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      nx[c] = 0;
      dreq[c] = (rem[c] > 0);
    end
    log_n = 0;
  endtask

  task automatic settle(input int cyc);
    repeat (cyc) @(negedge clk);
    dreq = '0;
    for (int c = 0; c < NCH; c++) rem[c] = 0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    logic [7:0] s;
    int rs;
    rs = $urandom(32'd20240517);
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk(!hrq && !ctl_oe && !d_oe && !adstb && dack == 0, "R1", "outputs after reset",
        {hrq, ctl_oe, d_oe, adstb, dack}, 0);
    check_regs("R1");
    cpu_rd(4'h8, s);
    chk(s == 0, "R1", "status after reset", s, 0);
    dreq = 4'hF;
    repeat (10) @(negedge clk);
    chk(!hrq, "R1", "no hold with cleared mode", hrq, 0);
    dreq = '0;

    // R2 window, R3 pointer reset
    wr16(2, 0, 16'h1234);
    wr16(2, 1, 16'h0005);
    rd16(2, 0, v); chk(v == 16'h1234, "R2", "addr ch2", v, 16'h1234);
    rd16(2, 1, v); chk(v == 16'h0005, "R2", "count ch2", v, 5);
    cpu_wr(4'h2, 8'hAA);
    wr_mode(8'h00);
    wr16(1, 0, 16'h2211);
    rd16(1, 0, v); chk(v == 16'h2211, "R3", "pointer reset by mode write", v, 16'h2211);

    // R4 disabled channel ignored
    wr_mode(8'h04);
    dreq = 4'b0010;
    repeat (10) @(negedge clk);
    chk(!hrq, "R4", "disabled request ignored", hrq, 0);
    rem[1] = 1; rem[2] = 1;
    start_reqs();
    dreq = 4'b0100;
    @(negedge clk);
    chk(hrq, "R4", "enabled request raises hrq", hrq, 1);
    settle(30);
    chk(nx[2] == 1, "R4", "one transfer ch2", nx[2], 1);

    // R5 priority order
    for (int c = 0; c < NCH; c++) begin
      wr16(c, 0, 16'h0100 * (c + 1) + 16'h10);
      wr16(c, 1, 16'h0003);
      rem[c] = 1;
    end
    wr_mode(8'h2F);
    start_reqs();
    settle(60);
    chk(log_n == 4, "R5", "four transfers", log_n, 4);
    for (int i = 0; i < 4; i++) chk(log_ch[i] == i, "R5", "serve order", log_ch[i], i);

    // R10 upper byte crossing, R7 readback
    wr16(0, 0, 16'h12FE);
    wr16(0, 1, 16'h0005);
    wr_mode(8'h01);
    rem[0] = 4;
    start_reqs();
    settle(60);
    chk(nx[0] == 4, "R10", "four transfers ch0", nx[0], 4);
    rd16(0, 0, v); chk(v == 16'h1302, "R7", "addr after 4", v, 16'h1302);
    rd16(0, 1, v); chk(v == 16'h0001, "R7", "count after 4", v, 1);
    check_status("R8");

    // R9 stop at terminal count
    wr16(3, 0, 16'h4000);
    wr16(3, 1, 16'h0001);
    wr_mode(8'h18);
    rem[3] = 5;
    start_reqs();
    repeat (60) @(negedge clk);
    chk(nx[3] == 2, "R9", "transfers before stop", nx[3], 2);
    chk(!hrq, "R9", "no hold after stop", hrq, 0);
    chk(mflag[3], "R8", "flag ch3 model", mflag[3], 1);
    settle(1);
    check_status("R8");
    check_regs("R7");

    // random rounds
    for (int r = 0; r < 20; r++) begin
      for (int c = 0; c < NCH; c++) begin
        wr16(c, 0, {8'($urandom), 8'hF8 | 8'($urandom % 8)});
        wr16(c, 1, 16'($urandom % 6));
        rem[c] = $urandom % 7;
      end
      wr_mode({2'b00, 1'($urandom), 1'($urandom), 4'($urandom)});
      start_reqs();
      settle(400);
      check_regs("R7");
      check_status("R8");
    end

    // R1 reset mid-run clears mode and registers
    wr_mode(8'h0F);
    @(negedge clk);
    rst_n = 0;
    model_clear();
    #1 chk(!hrq && !ctl_oe && !d_oe, "R1", "outputs in reset", {hrq, ctl_oe, d_oe}, 0);
    @(negedge clk);
    rst_n = 1;
    dreq = 4'hF;
    repeat (10) @(negedge clk);
    chk(!hrq, "R1", "mode cleared by reset", hrq, 0);
    dreq = '0;
    check_regs("R1");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule